// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog for a small processor subsystem. A one-cycle input tick at sub-clock rate is first divided by eight to form the watchdog tick. That tick passes through a fixed binary prescaler (divide by 512 at default parameters) and then through a programmable stage. The programmable stage divides by a power of two from 1 to 128, chosen by a 3-bit select code. When the whole chain reaches its end, the block raises a one-cycle reset request toward the processor and sets a sticky overflow flag. Software keeps the system alive by writing any value to the clear address before the chain runs out.

The register interface is a single write port and a combinational read port that share one address. Address 0 is the control register: bit 0 enables counting and bits 3:1 hold the select code. Writing any data to address 1 restarts the count. Address 2 bit 0 is the overflow flag, and writing a 1 to that bit clears it. A chip-level reset input (`sysRstN`) returns the block to its idle state but keeps the flag, so software can see after restart that the watchdog fired. Only power-on reset (`porN`) clears the flag.

Top module: `prescaled_watchdog`

## Requirements
- R1: After power-on reset, `resetReq` and `ovfFlag` are 0 and the control register reads 0, which means counting is disabled and the select code is 0. With counting disabled, no request occurs however many sub-clock ticks arrive.
- R2: The following holds while counting is enabled and `subTick` is high on every cycle. If a clear write happens on clock edge E0, `resetReq` is high in the cycle right after edge E0+N and low before that. Here N = 2^SUB_DIV_BITS × 2^PRE_BITS × 2^sel, which is 8 × 512 × 2^sel at default parameters.
- R3: Select codes 0 to 7 give programmable ratios of 1, 2, 4, 8, 16, 32, 64 and 128.
- R4: A clock edge on which `subTick` is low does not advance the count.
- R5: While the enable bit is 0 the count is frozen. When the bit is set to 1 again, counting resumes from the frozen value and no progress is lost.
- R6: A write of any data value to address 1 restarts the whole chain from zero. If that write falls on the edge that would have ended the count, the clear wins and no request is raised.
- R7: `resetReq` is high for exactly one cycle. A time-out restarts the count by itself, so a second request follows N edges later if software does nothing.
- R8: A time-out sets `ovfFlag`, which also reads back as bit 0 of address 2. Writing that address with bit 0 = 1 clears the flag. Writing it with bit 0 = 0 leaves the flag unchanged. If a time-out and a flag-clear write happen on the same edge, the set wins.
- R9: `sysRstN` low returns the control register and the count to their reset values but keeps `ovfFlag`. `porN` low clears `ovfFlag`.
- R10: A new select code written to the control register takes effect only at the next clear write or time-out. Until then the period already running keeps the old ratio.
- R11: Address 0 reads back as {0, select[2:0], enable}. Address 1 and address 3 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| porN | input | 1 | Power-on reset, active low, asynchronous; clears everything including the flag |
| sysRstN | input | 1 | Chip reset, active low, asynchronous; clears everything except the flag |
| subTick | input | 1 | One-cycle enable at sub-clock rate |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address for both write and read |
| wrData | input | DATA_W (8) | Write data |
| rdData | output | DATA_W (8) | Read data for `regAddr`, combinational |
| resetReq | output | 1 | One-cycle reset request on time-out |
| ovfFlag | output | 1 | Sticky overflow flag |

## Verification
The hardest conditions to reach are the ones where two events land on the same clock edge. The first is a clear write on the exact edge that would end the count. The second is a select change that must not touch the period already running. The bench reaches both by counting edges from a known clear, with a scaled-down prescaler parameter. This lets it place the clear on edge N and write the new select code one edge after the clear. It then confirms that the old period ends on time and that the automatic restart uses the new ratio. The enable freeze is pinned down the same way. The bench counts the ticks taken before the disabling write, and it checks that the remaining wait after re-enabling is exactly N minus those ticks.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CLEAR = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_FLAG  = 2'd2;

  // Strobes from the control half to the counting chain.
  typedef struct packed {
    logic advance;  // count one sub-clock tick this edge
    logic restart;  // zero the chain and reload the active select
  } wdt_strobe_t;

endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              coreRstN,
  input  logic              porN,
  input  logic              subTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              timeoutHit,
  output wdt_strobe_t       strobe,
  output logic [SEL_W-1:0]  selCfg,
  output logic [DATA_W-1:0] rdData,
  output logic              resetReq,
  output logic              ovfFlag
);

  logic enable;
  logic ctrlWr, clearWr, flagWr, timeoutEff;
  logic [DATA_W-1:0] ctrlView;
  wire unusedHiBits = ^wrData;

  assign ctrlWr  = wrEn && (regAddr == ADDR_CTRL);
  assign clearWr = wrEn && (regAddr == ADDR_CLEAR);
  assign flagWr  = wrEn && (regAddr == ADDR_FLAG);

  // A clear landing on the terminal edge suppresses the time-out.
  assign timeoutEff = timeoutHit && !clearWr;

  assign strobe.advance = enable && subTick;
  assign strobe.restart = clearWr || timeoutEff;

  always_ff @(posedge clk or negedge coreRstN) begin
    if (!coreRstN) begin
      enable <= 1'b0;
      selCfg <= '0;
    end else if (ctrlWr) begin
      enable <= wrData[0];
      selCfg <= wrData[SEL_W:1];
    end
  end

  always_ff @(posedge clk or negedge coreRstN) begin
    if (!coreRstN) resetReq <= 1'b0;
    else           resetReq <= timeoutEff;
  end

  // Flag sits on power-on reset only, so it outlives a chip reset.
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                     ovfFlag <= 1'b0;
    else if (timeoutEff)           ovfFlag <= 1'b1;
    else if (flagWr && wrData[0])  ovfFlag <= 1'b0;
  end

  always_comb begin
    ctrlView            = '0;
    ctrlView[0]         = enable;
    ctrlView[SEL_W:1]   = selCfg;
  end

  always_comb begin
    case (regAddr)
      ADDR_CTRL: rdData = ctrlView;
      ADDR_FLAG: rdData = DATA_W'(ovfFlag);
      default:   rdData = '0;
    endcase
  end

endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int SUB_DIV_BITS = 3,
  parameter int PRE_BITS     = 9,
  parameter int SEL_W        = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdt_strobe_t      strobe,
  input  logic [SEL_W-1:0] selCfg,
  output logic             timeoutHit
);

  localparam int POST_W = (1 << SEL_W) - 1;

  logic             divDone, preDone, postDone;
  logic [SEL_W-1:0] selActive;
  logic [POST_W-1:0] postCnt, postLimit;

  // Sub-clock divider: forms the watchdog tick.
  generate
    if (SUB_DIV_BITS > 0) begin : g_subdiv
      logic [SUB_DIV_BITS-1:0] divCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               divCnt <= '0;
        else if (strobe.restart) divCnt <= '0;
        else if (strobe.advance) divCnt <= divCnt + 1'b1;
      end
      assign divDone = &divCnt;
    end else begin : g_nosubdiv
      assign divDone = 1'b1;
    end
  endgenerate

  // Fixed prescaler: sets the base time-out.
  generate
    if (PRE_BITS > 0) begin : g_pre
      logic [PRE_BITS-1:0] preCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                          preCnt <= '0;
        else if (strobe.restart)            preCnt <= '0;
        else if (strobe.advance && divDone) preCnt <= preCnt + 1'b1;
      end
      assign preDone = &preCnt;
    end else begin : g_nopre
      assign preDone = 1'b1;
    end
  endgenerate

  // Programmable stage, ratio 2^selActive.
  assign postLimit = POST_W'((32'd1 << selActive) - 32'd1);
  assign postDone  = (postCnt == postLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      postCnt   <= '0;
      selActive <= '0;
    end else if (strobe.restart) begin
      postCnt   <= '0;
      selActive <= selCfg;
    end else if (strobe.advance && divDone && preDone) begin
      postCnt   <= postCnt + 1'b1;
    end
  end

  assign timeoutHit = strobe.advance && divDone && preDone && postDone;

endmodule

// File: rtl/prescaled_watchdog.sv
module prescaled_watchdog
  import wdt_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int SEL_W        = 3,
  parameter int PRE_BITS     = 9,
  parameter int SUB_DIV_BITS = 3
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              sysRstN,
  input  logic              subTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              resetReq,
  output logic              ovfFlag
);

  wdt_strobe_t      strobe;
  logic [SEL_W-1:0] selCfg;
  logic             timeoutHit;
  logic             coreRstN;

  assign coreRstN = porN & sysRstN;

  wdt_ctrl #(
    .DATA_W (DATA_W),
    .SEL_W  (SEL_W)
  ) i_ctrl (
    .clk        (clk),
    .coreRstN   (coreRstN),
    .porN       (porN),
    .subTick    (subTick),
    .wrEn       (wrEn),
    .regAddr    (regAddr),
    .wrData     (wrData),
    .timeoutHit (timeoutHit),
    .strobe     (strobe),
    .selCfg     (selCfg),
    .rdData     (rdData),
    .resetReq   (resetReq),
    .ovfFlag    (ovfFlag)
  );

  wdt_datapath #(
    .SUB_DIV_BITS (SUB_DIV_BITS),
    .PRE_BITS     (PRE_BITS),
    .SEL_W        (SEL_W)
  ) i_dp (
    .clk        (clk),
    .rstN       (coreRstN),
    .strobe     (strobe),
    .selCfg     (selCfg),
    .timeoutHit (timeoutHit)
  );

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
  import wdt_pkg::*;
(
  input logic              clk,
  input logic              porN,
  input logic              sysRstN,
  input logic              subTick,
  input logic              wrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic              w1cBit,
  input logic              resetReq,
  input logic              ovfFlag
);

  AST_REQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!porN || !sysRstN)
    resetReq |=> !resetReq); // R7

  AST_REQ_SETS_FLAG: assert property (@(posedge clk) disable iff (!porN || !sysRstN)
    resetReq |-> ovfFlag); // R8

  AST_FLAG_RISE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!porN)
    $rose(ovfFlag) |-> resetReq); // R8

  AST_CLEAR_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!porN || !sysRstN)
    (wrEn && regAddr == ADDR_CLEAR) |=> !resetReq); // R6

  AST_REQ_NEEDS_TICK: assert property (@(posedge clk) disable iff (!porN || !sysRstN)
    resetReq |-> $past(subTick)); // R4

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!porN)
    (ovfFlag && !(wrEn && regAddr == ADDR_FLAG && w1cBit)) |=> ovfFlag); // R9

endmodule

bind prescaled_watchdog wdt_checker i_wdt_checker (
  .clk      (clk),
  .porN     (porN),
  .sysRstN  (sysRstN),
  .subTick  (subTick),
  .wrEn     (wrEn),
  .regAddr  (regAddr),
  .w1cBit   (wrData[0]),
  .resetReq (resetReq),
  .ovfFlag  (ovfFlag)
);

// File: tb/test_prescaled_watchdog.sv
module test_prescaled_watchdog;
  import wdt_pkg::*;

  localparam int DW   = 8;
  localparam int SW   = 3;
  localparam int PB   = 3;   // scaled prescaler for run time
  localparam int SB   = 3;
  localparam int BASE = (1 << SB) * (1 << PB);  // 64 edges at ratio 1
  localparam int LIMIT = 20000;

  // {select code, expected edges from clear to request}
  localparam logic [18:0] VEC [8] = '{
    {3'd0, 16'd64},  {3'd1, 16'd128},  {3'd2, 16'd256},  {3'd3, 16'd512},
    {3'd4, 16'd1024}, {3'd5, 16'd2048}, {3'd6, 16'd4096}, {3'd7, 16'd8192}
  };

  logic clk = 1'b0;
  logic porN = 1'b0, sysRstN = 1'b1, subTick = 1'b0, wrEn = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic resetReq, ovfFlag;

  int nChecks = 0, nFail = 0;

  always #5 clk = ~clk;

  prescaled_watchdog #(.DATA_W(DW), .SEL_W(SW), .PRE_BITS(PB), .SUB_DIV_BITS(SB))
    i_prescaled_watchdog (
      .clk(clk), .porN(porN), .sysRstN(sysRstN), .subTick(subTick),
      .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData), .rdData(rdData),
      .resetReq(resetReq), .ovfFlag(ovfFlag));

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DW-1:0] d);
    wrEn = 1'b1; regAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output int v);
    regAddr = a;
    #1 v = int'(rdData);
  endtask

  task automatic waitReq(input bit alt, output int c);
    c = 0;
    while (c < LIMIT) begin
      c++;
      subTick = alt ? c[0] : 1'b1;
      @(negedge clk);
      if (resetReq) break;
    end
    subTick = 1'b1;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual 1 expected 0 (run hung)");
    finishRun();
  end

  initial begin
    int c, c2, v;
    repeat (3) @(negedge clk);
    check("R1 reset req", int'(resetReq), 0);
    check("R1 reset flag", int'(ovfFlag), 0);
    porN = 1'b1; subTick = 1'b1;
    @(negedge clk);
    rd(ADDR_CTRL, v); check("R1 ctrl after por", v, 0);
    c = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (resetReq) c++;
    end
    check("R1 no request while disabled", c, 0);

    // Table walk over all select codes.
    for (int i = 0; i < 8; i++) begin
      wr(ADDR_CTRL, {4'b0, VEC[i][18:16], 1'b1});
      wr(ADDR_CLEAR, 8'hA5 ^ 8'(i));
      waitReq(1'b0, c);
      check($sformatf("R2 R3 period sel %0d", i), c, int'(VEC[i][15:0]));
      @(negedge clk);
      check("R7 single-cycle pulse", int'(resetReq), 0);
      check("R8 flag set", int'(ovfFlag), 1);
      wr(ADDR_FLAG, 8'h01);
      rd(ADDR_FLAG, v); check("R8 flag cleared by w1", v, 0);
    end

    // Register readback.
    wr(ADDR_CTRL, 8'h0B);
    rd(ADDR_CTRL, v); check("R11 ctrl readback", v, 8'h0B);
    rd(ADDR_CLEAR, v); check("R11 clear reads zero", v, 0);
    rd(2'd3, v); check("R11 spare reads zero", v, 0);

    // Mid-count clear with data 0x00, then 0x5A.
    wr(ADDR_CTRL, 8'h03);
    wr(ADDR_CLEAR, 8'h00);
    repeat (100) @(negedge clk);
    wr(ADDR_CLEAR, 8'h5A);
    waitReq(1'b0, c);
    check("R6 clear restarts count", c, 2 * BASE);

    // Automatic restart after time-out.
    @(negedge clk);
    check("R7 pulse ends", int'(resetReq), 0);
    waitReq(1'b0, c2);
    check("R7 auto restart period", c2 + 1, 2 * BASE);

    // Clear on the terminal edge wins.
    wr(ADDR_FLAG, 8'h01);
    wr(ADDR_CLEAR, 8'h00);
    repeat (2 * BASE - 1) @(negedge clk);
    wr(ADDR_CLEAR, 8'hFF);
    check("R6 clear on terminal edge: no req", int'(resetReq), 0);
    check("R6 clear on terminal edge: no flag", int'(ovfFlag), 0);
    waitReq(1'b0, c);
    check("R6 period after race", c, 2 * BASE);

    // Sub-tick gaps.
    wr(ADDR_CLEAR, 8'h11);
    waitReq(1'b1, c);
    check("R4 half-rate ticks", c, 4 * BASE - 1);

    // Enable freeze.
    wr(ADDR_CLEAR, 8'h22);
    repeat (30) @(negedge clk);
    wr(ADDR_CTRL, 8'h02);
    c = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (resetReq) c++;
    end
    check("R5 frozen while disabled", c, 0);
    wr(ADDR_CTRL, 8'h03);
    waitReq(1'b0, c);
    check("R5 resumes without loss", c, 2 * BASE - 31);

    // Select change applies at next restart only.
    wr(ADDR_CTRL, 8'h01);
    wr(ADDR_CLEAR, 8'h33);
    wr(ADDR_CTRL, 8'h05);
    waitReq(1'b0, c);
    check("R10 old ratio kept", c, BASE - 1);
    @(negedge clk);
    waitReq(1'b0, c2);
    check("R10 new ratio after time-out", c2 + 1, 4 * BASE);

    // Flag write with bit0 = 0 keeps it.
    wr(ADDR_FLAG, 8'h00);
    rd(ADDR_FLAG, v); check("R8 write 0 keeps flag", v, 1);
    wr(ADDR_FLAG, 8'hFE);
    rd(ADDR_FLAG, v); check("R8 write FE keeps flag", v, 1);

    // Chip reset keeps flag; power-on reset clears it.
    sysRstN = 1'b0;
    @(negedge clk);
    sysRstN = 1'b1;
    rd(ADDR_CTRL, v); check("R9 chip reset clears ctrl", v, 0);
    check("R9 flag survives chip reset", int'(ovfFlag), 1);
    porN = 1'b0;
    @(negedge clk);
    porN = 1'b1;
    rd(ADDR_FLAG, v); check("R9 por clears flag", v, 0);
    check("R9 por clears flag port", int'(ovfFlag), 0);

    finishRun();
  end

endmodule